// File: doc/BRIEF.md
# Chip-Select Matcher with Spare-Rank Redirect

This block takes a normalized memory-controller input address and decides which of a small table of chip-selects claims it. Every table entry holds a base, a mask and an enable. An entry claims the address when it is enabled and the address agrees with the base on every bit the mask leaves uncovered. When more than one entry claims the address, the entry with the lowest index is chosen.

After the match, an online-spare rule may reroute the result. If the matched index is the rank nominated as bad, and a spare rank number is configured, the result becomes the spare's index. The spare entry's own base, mask and enable play no part in this. A spare number that names no table entry leaves the matched index in place and raises a redirect-failure flag.

A format input selects one of two register layouts. In the current layout, fixed bit masks are applied to the stored base and mask. In the older layout, different fixed masks are applied and the address is shifted left by four before the comparison. The table is loaded through a write port indexed by entry number. A lookup is evaluated combinationally in the cycle it is presented, and its result is registered.

Top module: `cs_select_unit`

## Requirements
- R1: When `wr_en` is high, the base, mask and enable on the write inputs are stored into entry `wr_idx` at the clock edge. A lookup presented in the same cycle as a write is evaluated against the table contents from before that write.
- R2: An entry responds only when its enable is 1 and (address AND NOT mask) equals (base AND NOT mask). The base and mask used here are the format-adjusted values.
- R3: A disabled entry never responds, whatever its base and mask hold.
- R4: When several entries respond, the lowest index is reported.
- R5: When no entry responds, the result has `res_noaddr`=1, `res_hit`=0, `res_redirect_fail`=0 and `res_cs`=4'hF.
- R6: `res_valid` is 1 exactly in the cycle after a cycle with `lookup_valid`=1. While no lookup is issued, the result fields keep their last values.
- R7: If the matched index equals `bad_rank` and `spare_rank` is not 4'hF, and `spare_rank` is below the entry count (8), then `res_cs`=`spare_rank`, `res_hit`=1 and `res_redirect_fail`=0.
- R8: No redirection happens when `spare_rank` is 4'hF. This includes the case where both `bad_rank` and `spare_rank` are 4'hF, the invalid marker. No redirection happens either when the matched index differs from `bad_rank`.
- R9: If a redirection applies but `spare_rank` is 8 through 14, so that no such entry exists, then `res_redirect_fail`=1, `res_hit`=1 and `res_cs` stays at the matched index.
- R10: With `legacy_fmt`=0, the effective base is raw AND 32'h1FF83FE0 and the effective mask is (raw OR 32'h0007C01F) AND 32'h1FFFFFFF. The address is compared unshifted, so address bits 18:14 and 4:0 are never compared, while bits 31:29 and 13:5 are.
- R11: With `legacy_fmt`=1, the effective base is raw AND 32'hFFE0FE00 and the effective mask is (raw OR 32'h001F01FF) AND 32'h3FFFFFFF. The address is shifted left by 4 before the comparison.
- R12: Reset clears every entry to disabled and sets `res_valid`=0, `res_hit`=0, `res_noaddr`=0, `res_redirect_fail`=0 and `res_cs`=4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | 3 | Entry number to write |
| wr_base | input | 32 | Raw base value to store |
| wr_mask | input | 32 | Raw mask value to store |
| wr_enable | input | 1 | Enable bit to store |
| legacy_fmt | input | 1 | 1 selects the older register layout and the address pre-shift |
| bad_rank | input | 4 | Nominated failed rank, 4'hF when none |
| spare_rank | input | 4 | Spare rank number, 4'hF when none |
| lookup_valid | input | 1 | Evaluate `lookup_addr` in this cycle |
| lookup_addr | input | 32 | Normalized input address |
| res_valid | output | 1 | Result registered from the previous cycle's lookup |
| res_hit | output | 1 | An entry claimed the address |
| res_noaddr | output | 1 | No entry claimed the address |
| res_redirect_fail | output | 1 | Redirect requested but the spare entry does not exist |
| res_cs | output | 4 | Final chip-select index, 4'hF when there is no hit |

## Verification
Two functions can act on one lookup in the same cycle, and the bench provokes both pairings. The first pairing is the write port and the matcher. The bench writes entry 7 and looks up that entry's own address on the same edge. The first result must be a miss, because the old contents apply, and a repeat lookup must then hit entry 7. The second pairing is the priority match and the spare reroute. The bench looks up an address that the bad rank claims, under several spare settings: a real spare, an invalid marker, a nonexistent index, and a bad rank that is not the matched one. It judges `res_cs`, `res_hit` and `res_redirect_fail` together in the cycle after each lookup.

// File: rtl/cs_sel_pkg.sv
package cs_sel_pkg;

  localparam int ADDR_W = 32;

  // current layout
  localparam logic [ADDR_W-1:0] CUR_BASE_KEEP = 32'h1FF8_3FE0;
  localparam logic [ADDR_W-1:0] CUR_MASK_SET  = 32'h0007_C01F;
  localparam logic [ADDR_W-1:0] CUR_MASK_KEEP = 32'h1FFF_FFFF;
  // older layout
  localparam logic [ADDR_W-1:0] OLD_BASE_KEEP = 32'hFFE0_FE00;
  localparam logic [ADDR_W-1:0] OLD_MASK_SET  = 32'h001F_01FF;
  localparam logic [ADDR_W-1:0] OLD_MASK_KEEP = 32'h3FFF_FFFF;
  localparam int               OLD_ADDR_SHL  = 4;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
  } cs_entry_t;

  function automatic logic [ADDR_W-1:0] eff_base(input logic [ADDR_W-1:0] raw,
                                                 input logic legacy);
    return legacy ? (raw & OLD_BASE_KEEP) : (raw & CUR_BASE_KEEP);
  endfunction

  function automatic logic [ADDR_W-1:0] eff_mask(input logic [ADDR_W-1:0] raw,
                                                 input logic legacy);
    return legacy ? ((raw | OLD_MASK_SET) & OLD_MASK_KEEP)
                  : ((raw | CUR_MASK_SET) & CUR_MASK_KEEP);
  endfunction

  function automatic logic [ADDR_W-1:0] eff_addr(input logic [ADDR_W-1:0] raw,
                                                 input logic legacy);
    return legacy ? (raw << OLD_ADDR_SHL) : raw;
  endfunction

  function automatic logic entry_responds(input cs_entry_t e,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic legacy);
    logic [ADDR_W-1:0] m;
    logic [ADDR_W-1:0] b;
    logic [ADDR_W-1:0] a;
    m = eff_mask(e.mask, legacy);
    b = eff_base(e.base, legacy);
    a = eff_addr(addr, legacy);
    return e.en && ((a & ~m) == (b & ~m));
  endfunction

endpackage

// File: rtl/cs_table.sv
module cs_table
  import cs_sel_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  cs_entry_t        wr_data,
  output cs_entry_t        entries [NUM_CS],
  output logic [NUM_CS-1:0] en_vec
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ent
    cs_entry_t ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q <= '0;
      else if (wr_en && (wr_idx == SEL_W'(g)))
        ent_q <= wr_data;
    end
    assign entries[g] = ent_q;
    assign en_vec[g]  = ent_q.en;
  end

endmodule

// File: rtl/cs_compare.sv
module cs_compare
  import cs_sel_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  cs_entry_t          entries [NUM_CS],
  input  logic [ADDR_W-1:0]  addr,
  input  logic               legacy,
  output logic [NUM_CS-1:0]  match_vec
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    assign match_vec[g] = entry_responds(entries[g], addr, legacy);
  end

endmodule

// File: rtl/cs_prio.sv
module cs_prio #(
  parameter int NUM_CS = 8,
  parameter int IDX_W  = 4
) (
  input  logic [NUM_CS-1:0] match_vec,
  output logic              any_match,
  output logic [IDX_W-1:0]  first_idx
);

  localparam logic [IDX_W-1:0] INV = '1;

  always_comb begin
    first_idx = INV;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match_vec[i]) first_idx = IDX_W'(i);
    end
  end

  assign any_match = |match_vec;

endmodule

// File: rtl/cs_spare_redirect.sv
module cs_spare_redirect #(
  parameter int NUM_CS = 8,
  parameter int IDX_W  = 4
) (
  input  logic             any_match,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] bad_rank,
  input  logic [IDX_W-1:0] spare_rank,
  output logic             redir_take,
  output logic             redir_fail,
  output logic [IDX_W-1:0] final_idx,
  output logic             hit,
  output logic             noaddr
);

  localparam logic [IDX_W-1:0] INV = '1;
  localparam logic [IDX_W-1:0] CNT = IDX_W'(NUM_CS);

  logic both_unset;
  logic spare_set;
  logic spare_exists;

  assign both_unset   = (bad_rank == INV) && (spare_rank == INV);
  assign spare_set    = (spare_rank != INV);
  assign spare_exists = (spare_rank < CNT);

  assign redir_take = any_match && !both_unset && spare_set && (first_idx == bad_rank);
  assign redir_fail = redir_take && !spare_exists;

  always_comb begin
    if (!any_match)
      final_idx = INV;
    else if (redir_take && spare_exists)
      final_idx = spare_rank;
    else
      final_idx = first_idx;
  end

  assign hit    = any_match;
  assign noaddr = !any_match;

endmodule

// File: rtl/cs_select_unit.sv
module cs_select_unit
  import cs_sel_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int IDX_W = $clog2(NUM_CS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  logic [31:0]      wr_base,
  input  logic [31:0]      wr_mask,
  input  logic             wr_enable,
  input  logic             legacy_fmt,
  input  logic [IDX_W-1:0] bad_rank,
  input  logic [IDX_W-1:0] spare_rank,
  input  logic             lookup_valid,
  input  logic [31:0]      lookup_addr,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_noaddr,
  output logic             res_redirect_fail,
  output logic [IDX_W-1:0] res_cs
);

  localparam logic [IDX_W-1:0] INV = '1;

  cs_entry_t         wr_data;
  cs_entry_t         entries [NUM_CS];
  logic [NUM_CS-1:0] en_vec;
  logic [NUM_CS-1:0] match_vec;
  logic              any_match;
  logic [IDX_W-1:0]  first_idx;
  logic              redir_take;
  logic              redir_fail;
  logic [IDX_W-1:0]  final_idx;
  logic              hit_c;
  logic              noaddr_c;

  assign wr_data = '{en: wr_enable, base: wr_base, mask: wr_mask};

  cs_table #(.NUM_CS(NUM_CS)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .entries (entries),
    .en_vec  (en_vec)
  );

  cs_compare #(.NUM_CS(NUM_CS)) u_cmp (
    .entries   (entries),
    .addr      (lookup_addr),
    .legacy    (legacy_fmt),
    .match_vec (match_vec)
  );

  cs_prio #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_prio (
    .match_vec (match_vec),
    .any_match (any_match),
    .first_idx (first_idx)
  );

  cs_spare_redirect #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_redir (
    .any_match  (any_match),
    .first_idx  (first_idx),
    .bad_rank   (bad_rank),
    .spare_rank (spare_rank),
    .redir_take (redir_take),
    .redir_fail (redir_fail),
    .final_idx  (final_idx),
    .hit        (hit_c),
    .noaddr     (noaddr_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid         <= 1'b0;
      res_hit           <= 1'b0;
      res_noaddr        <= 1'b0;
      res_redirect_fail <= 1'b0;
      res_cs            <= INV;
    end else begin
      res_valid <= lookup_valid;
      if (lookup_valid) begin
        res_hit           <= hit_c;
        res_noaddr        <= noaddr_c;
        res_redirect_fail <= redir_fail;
        res_cs            <= final_idx;
      end
    end
  end

endmodule

// File: rtl/cs_select_chk.sv
module cs_select_chk #(
  parameter int NUM_CS = 8,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lookup_valid,
  input logic [IDX_W-1:0]  bad_rank,
  input logic [IDX_W-1:0]  spare_rank,
  input logic [NUM_CS-1:0] match_vec,
  input logic [NUM_CS-1:0] en_vec,
  input logic              redir_take,
  input logic              res_valid,
  input logic              res_hit,
  input logic              res_noaddr,
  input logic              res_redirect_fail,
  input logic [IDX_W-1:0]  res_cs
);

  localparam logic [IDX_W-1:0] INV = '1;
  localparam logic [IDX_W-1:0] CNT = IDX_W'(NUM_CS);

  assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec & ~en_vec) == '0);

  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && match_vec[0] && bad_rank != '0) |=> (res_cs == '0));

  assert_miss_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && match_vec == '0) |=> (res_noaddr && !res_hit && res_cs == INV));

  assert_hit_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_noaddr));

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> res_valid);

  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> (!res_valid && $stable(res_cs)));

  assert_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && redir_take && spare_rank < CNT)
      |=> (res_cs == $past(spare_rank) && !res_redirect_fail && res_hit));

  assert_no_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_rank == INV) |-> !redir_take);

  assert_fail_keeps_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_redirect_fail |-> res_hit);

endmodule

bind cs_select_unit cs_select_chk #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .lookup_valid      (lookup_valid),
  .bad_rank          (bad_rank),
  .spare_rank        (spare_rank),
  .match_vec         (match_vec),
  .en_vec            (en_vec),
  .redir_take        (redir_take),
  .res_valid         (res_valid),
  .res_hit           (res_hit),
  .res_noaddr        (res_noaddr),
  .res_redirect_fail (res_redirect_fail),
  .res_cs            (res_cs)
);

// File: tb/tb_cs_select_unit.sv
module tb_cs_select_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [31:0] wr_base;
  logic [31:0] wr_mask;
  logic        wr_enable;
  logic        legacy_fmt;
  logic [3:0]  bad_rank;
  logic [3:0]  spare_rank;
  logic        lookup_valid;
  logic [31:0] lookup_addr;
  logic        res_valid;
  logic        res_hit;
  logic        res_noaddr;
  logic        res_redirect_fail;
  logic [3:0]  res_cs;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cs_select_unit dut (.*);

  typedef struct packed {
    logic        legacy;
    logic [31:0] addr;
    logic [3:0]  bad;
    logic [3:0]  spare;
    logic        hit;
    logic        noaddr;
    logic        fail;
    logic [3:0]  cs;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0010_0000, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 4'h0}, // R2 plain hit
    '{1'b0, 32'h0010_001F, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 4'h0}, // R10 bits 4:0 ignored
    '{1'b0, 32'h0017_C000, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 4'h0}, // R10 bits 18:14 ignored
    '{1'b0, 32'h0010_0020, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0, 4'hF}, // R10 bit 5 compared
    '{1'b0, 32'h2010_0000, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0, 4'hF}, // R10 bit 29 compared
    '{1'b0, 32'h0028_0000, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 4'h1}, // R2 mask bit
    '{1'b0, 32'h0020_0000, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 4'h1}, // R4 entries 1,2
    '{1'b0, 32'h0040_0000, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0, 4'hF}, // R3 disabled
    '{1'b0, 32'h0200_1FE0, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 4'h6}, // R2 wide mask
    '{1'b0, 32'h0080_0000, 4'h4, 4'h5, 1'b1, 1'b0, 1'b0, 4'h5}, // R7 to spare
    '{1'b0, 32'h0080_0000, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 4'h4}, // R8 both unset
    '{1'b0, 32'h0080_0000, 4'h4, 4'hF, 1'b1, 1'b0, 1'b0, 4'h4}, // R8 spare unset
    '{1'b0, 32'h0080_0000, 4'h4, 4'h9, 1'b1, 1'b0, 1'b1, 4'h4}, // R9 no entry 9
    '{1'b0, 32'h0080_0000, 4'h4, 4'hE, 1'b1, 1'b0, 1'b1, 4'h4}, // R9 no entry 14
    '{1'b0, 32'h0010_0000, 4'h4, 4'h5, 1'b1, 1'b0, 1'b0, 4'h0}, // R8 other rank
    '{1'b0, 32'h0040_0000, 4'h3, 4'h5, 1'b0, 1'b1, 1'b0, 4'hF}, // R5 bad rank disabled
    '{1'b0, 32'h0010_0000, 4'h0, 4'h7, 1'b1, 1'b0, 1'b0, 4'h7}, // R7 spare unwritten
    '{1'b1, 32'h0000_0010, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 4'h0}, // R11 low bits free
    '{1'b1, 32'h0002_0000, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 4'h1}, // R11 shift by 4
    '{1'b1, 32'h0000_0020, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0, 4'hF}, // R11 bit 9 compared
    '{1'b1, 32'h0001_0000, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 4'h0}, // R11 bits 20:16 free
    '{1'b1, 32'h0008_0000, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 4'h4}  // R11 bit 23
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_entry(input logic [2:0] idx, input logic [31:0] b,
                             input logic [31:0] m, input logic en);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_base = b; wr_mask = m; wr_enable = en;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic leg, input logic [31:0] a,
                        input logic [3:0] bad, input logic [3:0] spare);
    @(negedge clk);
    legacy_fmt = leg; lookup_addr = a; bad_rank = bad; spare_rank = spare;
    lookup_valid = 1'b1;
    @(negedge clk);
    lookup_valid = 1'b0;
  endtask

  task automatic check_result(input string req, input logic hit, input logic noaddr,
                              input logic fail, input logic [3:0] cs);
    check({req, " valid"},  {31'd0, res_valid}, 32'd1);
    check({req, " hit"},    {31'd0, res_hit}, {31'd0, hit});
    check({req, " noaddr"}, {31'd0, res_noaddr}, {31'd0, noaddr});
    check({req, " fail"},   {31'd0, res_redirect_fail}, {31'd0, fail});
    check({req, " cs"},     {28'd0, res_cs}, {28'd0, cs});
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_base = '0; wr_mask = '0;
    wr_enable = 1'b0; legacy_fmt = 1'b0; bad_rank = 4'hF; spare_rank = 4'hF;
    lookup_valid = 1'b0; lookup_addr = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 valid",  {31'd0, res_valid}, 32'd0);
    check("R12 hit",    {31'd0, res_hit}, 32'd0);
    check("R12 noaddr", {31'd0, res_noaddr}, 32'd0);
    check("R12 fail",   {31'd0, res_redirect_fail}, 32'd0);
    check("R12 cs",     {28'd0, res_cs}, 32'hF);
    rst_n = 1'b1;

    // R1 table load
    write_entry(3'd0, 32'h0010_0000, 32'h0000_0000, 1'b1);
    write_entry(3'd1, 32'h0020_0000, 32'h0008_0000, 1'b1);
    write_entry(3'd2, 32'h0020_0000, 32'h0000_0000, 1'b1);
    write_entry(3'd3, 32'h0040_0000, 32'h0000_0000, 1'b0);
    write_entry(3'd4, 32'h0080_0000, 32'h0000_0000, 1'b1);
    write_entry(3'd5, 32'h0100_0000, 32'h0000_0000, 1'b0);
    write_entry(3'd6, 32'h0200_0000, 32'h0000_3FE0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].legacy, VECS[i].addr, VECS[i].bad, VECS[i].spare);
      check_result($sformatf("vec%0d", i), VECS[i].hit, VECS[i].noaddr,
                   VECS[i].fail, VECS[i].cs);
    end

    // R1 write and lookup on the same edge: old contents apply
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd7; wr_base = 32'h0800_0000; wr_mask = '0; wr_enable = 1'b1;
    legacy_fmt = 1'b0; lookup_addr = 32'h0800_0000; bad_rank = 4'hF; spare_rank = 4'hF;
    lookup_valid = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; lookup_valid = 1'b0;
    check_result("R1 same-cycle", 1'b0, 1'b1, 1'b0, 4'hF);
    lookup(1'b0, 32'h0800_0000, 4'hF, 4'hF);
    check_result("R1 after write", 1'b1, 1'b0, 1'b0, 4'h7);

    // R6 idle cycle: valid drops, fields hold
    @(negedge clk);
    check("R6 idle valid", {31'd0, res_valid}, 32'd0);
    check("R6 idle cs",    {28'd0, res_cs}, 32'h7);
    check("R6 idle hit",   {31'd0, res_hit}, 32'd1);

    // R12 reset clears the table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lookup(1'b0, 32'h0010_0000, 4'hF, 4'hF);
    check_result("R12 table cleared", 1'b0, 1'b1, 1'b0, 4'hF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule